// File: doc/BRIEF.md
# Synchronous Host Bus Register Slave

This block lets a host processor read and write a small bank of byte registers over a synchronous bus that runs on the host's own clock, which may be as fast as 33 MHz. Every input is sampled on the rising edge of that clock. Every output changes only on that edge: the read data, its output enable and the ready flag. A transfer has two phases. In the first, the block sees chip select low for the first time and captures the address and the direction on that same edge. In the second, a separate enable finishes the cycle: the data-bus enable for a read, or the write strobe for a write.

When the cycle finishes, ready goes high for one clock. The block then ignores the bus until chip select has been sampled high again. The 8-bit data bus is split into an input byte, an output byte and an output enable, and the pad ring joins them into one bidirectional pin group. The register bank has 32 entries. An entry is chosen by the low five bits of the 15-bit address, and only when all the upper address bits are zero.

Top module: `sync_host_slave`

## Requirements
- R1: After reset, `rdy` is 0, `dout_en` is 0, and every register entry reads 0x00.
- R2: The address and the direction are captured on the first rising edge where `cs_n` is sampled low. Later changes on `addr` before the cycle ends have no effect on which entry is accessed.
- R3: In a read cycle, `dout_en` stays 0 until `oe_n` is sampled low. On that edge, `dout` takes the addressed entry's value and `dout_en` becomes 1.
- R4: In a write cycle, the value of `din` sampled on the edge where `ws_n` is first seen low is stored into the captured entry.
- R5: `rdy` is 1 for exactly one clock, starting on the edge where read data is driven or write data is stored.
- R6: After a cycle completes, no new cycle starts until `cs_n` has been sampled high. Strobes seen before that write nothing and raise no `rdy`.
- R7: `dout_en` is cleared on any edge where `cs_n` or `oe_n` is sampled high. While both stay low after a read, the bus remains driven with the same value.
- R8: An address is mapped when bits 14:5 are all zero, and bits 4:0 select one of 32 entries. A read of an unmapped address returns 0x00. A write to an unmapped address changes no entry.
- R9: If `cs_n` is sampled high before the finishing enable, the cycle is abandoned. Nothing is written and `rdy` stays 0.
- R10: `rnw` sampled 1 marks a read and 0 marks a write. `ws_n` has no effect in a read cycle, and `oe_n` does not drive the bus in a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rnw | input | 1 | Direction: 1 read, 0 write |
| addr | input | 15 | Register address |
| oe_n | input | 1 | Data-bus enable, active low, finishes a read |
| ws_n | input | 1 | Write strobe, active low, finishes a write |
| din | input | 8 | Data bus input byte |
| dout | output | 8 | Data bus output byte |
| dout_en | output | 1 | Output enable for the data bus pads |
| rdy | output | 1 | Transfer-complete flag, one clock wide |

## Verification
The bench moves the address lines to the inverted address during every data phase. A design that samples the address late would then hit the wrong entry, and the readback would show it. It holds chip select low after a finished write and pulses the strobe again with new data. A design that rearms without seeing chip select high would overwrite the entry or raise ready twice. It also drops chip select before any strobe, writes with bit 5 set and swaps the strobes between directions. Each of these catches a design that writes on an abandoned cycle, aliases unmapped space onto the bank, or lets the wrong enable drive or store. It ends a read once by raising the enable alone, to catch a bus that stays driven after the enable is withdrawn.

// File: rtl/shb_pkg.sv
package shb_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_DONE  = 2'd3
    } cyc_state_e;

endpackage

// File: rtl/shb_cycle_ctrl.sv
module shb_cycle_ctrl
    import shb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              ws_n,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              rdy
);

    typedef struct packed {
        cyc_state_e        st;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] dat;
        logic              doe;
        logic              rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_en_d;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rdy = 1'b0;
        wr_en_d   = 1'b0;
        // the bus stays driven only while both selects remain low
        ctl_d.doe = ctl_q.doe & ~cs_n & ~oe_n;
        unique case (ctl_q.st)
            CYC_IDLE: begin
                if (!cs_n) begin
                    ctl_d.adr = addr;
                    ctl_d.st  = rnw ? CYC_READ : CYC_WRITE;
                end
            end
            CYC_READ: begin
                if (cs_n) begin
                    ctl_d.st = CYC_IDLE;
                end else if (!oe_n) begin
                    ctl_d.dat = rd_data;
                    ctl_d.doe = 1'b1;
                    ctl_d.rdy = 1'b1;
                    ctl_d.st  = CYC_DONE;
                end
            end
            CYC_WRITE: begin
                if (cs_n) begin
                    ctl_d.st = CYC_IDLE;
                end else if (!ws_n) begin
                    wr_en_d   = 1'b1;
                    ctl_d.rdy = 1'b1;
                    ctl_d.st  = CYC_DONE;
                end
            end
            CYC_DONE: begin
                if (cs_n) begin
                    ctl_d.st = CYC_IDLE;
                end
            end
            default: ctl_d.st = CYC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: CYC_IDLE, adr: '0, dat: '0, doe: 1'b0, rdy: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign lat_addr = ctl_q.adr;
    assign wr_en    = wr_en_d;
    assign dout     = ctl_q.dat;
    assign dout_en  = ctl_q.doe;
    assign rdy      = ctl_q.rdy;

endmodule

// File: rtl/shb_regfile.sv
module shb_regfile #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int HI_W  = ADDR_W - IDX_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic [HI_W-1:0]   hi_bits;
    logic              hit;

    assign idx     = acc_addr[IDX_W-1:0];
    assign hi_bits = acc_addr[ADDR_W-1:IDX_W];
    assign hit     = (hi_bits == '0);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && hit) begin
            mem_d[idx] = wr_data;
        end
        rd_data = hit ? mem_q[idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

endmodule

// File: rtl/sync_host_slave.sv
module sync_host_slave #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              ws_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              rdy
);

    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;

    shb_cycle_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rnw      (rnw),
        .addr     (addr),
        .oe_n     (oe_n),
        .ws_n     (ws_n),
        .rd_data  (rd_data),
        .lat_addr (lat_addr),
        .wr_en    (wr_en),
        .dout     (dout),
        .dout_en  (dout_en),
        .rdy      (rdy)
    );

    shb_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_addr (lat_addr),
        .wr_en    (wr_en),
        .wr_data  (din),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/sync_host_slave_chk.sv
module sync_host_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              rdy
);

    // R5: ready never lasts longer than one clock
    a_r5_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R9: ready needs chip select low at the sampling edge
    a_r9_rdy_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> $past(!cs_n));

    // R7: the bus is driven only if both selects were sampled low
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> ($past(!cs_n) && $past(!oe_n)));

    // R3: the bus is turned on only together with ready
    a_r3_drive_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> rdy);

    // R7: a held drive keeps the same value
    a_r7_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en)) |-> $stable(dout));

endmodule

bind sync_host_slave sync_host_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_en (dout_en),
    .rdy     (rdy)
);

// File: tb/sync_host_slave_test.sv
`timescale 1ns/1ps
module sync_host_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rnw = 1'b1;
    logic [14:0] addr = '0;
    logic        oe_n = 1'b1;
    logic        ws_n = 1'b1;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        rdy;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] model [32];
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    sync_host_slave uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rnw(rnw), .addr(addr),
        .oe_n(oe_n), .ws_n(ws_n), .din(din), .dout(dout),
        .dout_en(dout_en), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected byte when a read completes
    always @(negedge clk) begin
        if (rst_n && rdy && dout_en) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected read drive", dout, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(dout == e, "R2 R3 R8 read data", dout, e);
            end
        end
    end

    function automatic bit mapped(input logic [14:0] a);
        return a[14:5] == '0;
    endfunction

    task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit oe_too);
        @(negedge clk); cs_n = 0; rnw = 0; addr = a;
        @(negedge clk); addr = ~a; din = d; ws_n = 0; oe_n = oe_too ? 1'b0 : 1'b1;
        chk(rdy == 0, "R4 no ready before strobe", rdy, 0);
        @(negedge clk);
        chk(rdy == 1, "R5 write ready", rdy, 1);
        chk(dout_en == 0, "R10 write does not drive", dout_en, 0);
        ws_n = 1; oe_n = 1; din = ~d; cs_n = 1;
        if (mapped(a)) model[a[4:0]] = d;
        @(negedge clk);
        chk(rdy == 0, "R5 ready one clock", rdy, 1'b0);
    endtask

    task automatic do_read(input logic [14:0] a, input bit drop_oe_only, input bit ws_too);
        logic [7:0] e;
        e = mapped(a) ? model[a[4:0]] : 8'h00;
        @(negedge clk); cs_n = 0; rnw = 1; addr = a;
        @(negedge clk);
        chk(dout_en == 0, "R3 no drive before enable", dout_en, 0);
        addr = ~a; oe_n = 0; ws_n = ws_too ? 1'b0 : 1'b1; din = 8'h5A;
        exp_q.push_back(e);
        @(negedge clk);
        chk(rdy == 1, "R5 read ready", rdy, 1);
        ws_n = 1;
        @(negedge clk);
        chk(rdy == 0, "R5 ready one clock", rdy, 0);
        chk(dout_en == 1, "R7 held while enabled", dout_en, 1);
        chk(exp_q.size() == 0, "R3 read produced data", exp_q.size(), 0);
        if (drop_oe_only) oe_n = 1;
        else begin cs_n = 1; oe_n = 1; end
        @(negedge clk);
        chk(dout_en == 0, "R7 bus released", dout_en, 0);
        cs_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(rdy == 0, "R1 reset ready", rdy, 0);
        chk(dout_en == 0, "R1 reset drive", dout_en, 0);
        rst_n = 1;
        @(negedge clk);
        do_read(15'd9, 0, 0);                    // R1 reset contents
        do_write(15'd3, 8'hC3, 0);               // R4
        do_read(15'd3, 0, 0);                    // R2 address change ignored
        do_write(15'd31, 8'h7E, 1);              // R10 oe during write
        do_read(15'd31, 1, 0);                   // R7 release by enable alone
        do_write(15'd0, 8'h01, 0);
        do_read(15'd0, 0, 1);                    // R10 strobe during read ignored
        do_read(15'd0, 0, 0);
        // R8: unmapped write dropped, unmapped read is zero
        do_write(15'h0025, 8'hAB, 0);
        do_read(15'h0025, 0, 0);
        do_read(15'd5, 0, 0);
        do_write(15'h4003, 8'hEE, 0);
        do_read(15'd3, 0, 0);
        // R6: chip select held low after completion
        @(negedge clk); cs_n = 0; rnw = 0; addr = 15'd7;
        @(negedge clk); ws_n = 0; din = 8'h11;
        @(negedge clk); chk(rdy == 1, "R6 first write ready", rdy, 1); ws_n = 1;
        model[7] = 8'h11;
        @(negedge clk); ws_n = 0; din = 8'h99;
        chk(rdy == 0, "R6 ready drops", rdy, 0);
        @(negedge clk); chk(rdy == 0, "R6 no rearm", rdy, 0);
        @(negedge clk); chk(rdy == 0, "R6 no rearm later", rdy, 0);
        ws_n = 1; cs_n = 1;
        @(negedge clk);
        do_read(15'd7, 0, 0);
        // R9: abandoned write
        @(negedge clk); cs_n = 0; rnw = 0; addr = 15'd7;
        @(negedge clk); cs_n = 1; din = 8'h44;
        @(negedge clk); ws_n = 0;
        chk(rdy == 0, "R9 no ready on abort", rdy, 0);
        @(negedge clk); chk(rdy == 0, "R9 no ready after abort", rdy, 0);
        ws_n = 1;
        @(negedge clk);
        do_read(15'd7, 0, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule